// File: doc/BRIEF.md
# I2C Register-File Target with Coherent Clock Snapshot

This block is an I2C target that gives a bus master access to a 20-byte register space at addresses 00h to 13h. A single byte-wide word pointer selects the register. A write transfer loads the pointer from its first data byte and stores any further bytes at consecutive addresses. A read transfer streams bytes from the pointer onward. It can follow a pointer-loading write through a repeated START, or it can begin directly from wherever the last transfer left the pointer.

The lowest eight registers show a 64-bit time value supplied on an input bus, one byte per address with byte 0 the least significant. These registers copy the live value on every system clock. The copying stops while the target is addressed and the pointer sits in 00h-07h, so a burst read of the time bytes returns one consistent snapshot. SCL and SDA are oversampled by the system clock through synchronizers. SDA is driven as open drain through an output-enable.

Top module: `i2c_rf_top`

## Requirements
- R1: The target acknowledges only the 7-bit address 1101000b (address bytes D0h for write and D1h for read). For any other address it gives no acknowledge, keeps SDA released for the rest of that transfer, and leaves the pointer and registers untouched.
- R2: In a write transfer, the first byte after the address loads the pointer, and a value of 14h or above loads 00h. Each later byte is acknowledged and stored at the pointer, and the pointer then steps by one.
- R3: After a repeated START and the read address, the target sends the byte at the pointer. Each master ACK steps the pointer by one and the next byte follows, MSB first.
- R4: A master NACK ends the read. SDA then stays released until the next START or STOP.
- R5: A read started without a pointer write begins at the address the pointer held when the previous transfer ended.
- R6: The pointer is 00h after reset and wraps from 13h to 00h.
- R7: While not frozen, register k (00h-07h) reads as bits [8k+7:8k] of the time input.
- R8: While the target is addressed and the pointer is in 00h-07h, the clock registers hold their values, so a multi-byte read returns one snapshot even if the time input changes.
- R9: Copying of time data resumes on a STOP, and also as soon as the pointer steps into 08h-13h within a transfer.
- R10: After reset, SDA is released and registers 08h-13h read 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| time_i | input | 64 | Live time value, byte k mirrored at address k |
| sda_oe | output | 1 | When high the pad pulls SDA low |

## Verification
The bench builds the block with its default parameters: 20 registers of which 8 are clock registers, target address 68h and two synchronizer stages. With only 20 addresses, one burst read crosses the clock/data boundary and wraps 13h to 00h, so the resume-on-increment rule and the re-freeze after the wrap are both observable in a single transfer. The 64-bit time bus lets the bench change every clock byte between bytes of a burst and tell a frozen byte from a refreshed one.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_HOLD
    } eng_state_e;

    // Conditioned bus events, one system clock wide
    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // Registered write request towards the register file
    typedef struct packed {
        logic  en;
        byte_t addr;
        byte_t data;
    } reg_wr_t;

    // Pointer advance with wrap at the last address
    function automatic byte_t ptr_step(input byte_t cur, input byte_t last);
        return (cur >= last) ? 8'd0 : cur + 8'd1;
    endfunction

endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync
    import i2c_rf_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= scl_i;
                    sda_q <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= {scl_q[STAGES-2:0], scl_i};
                    sda_q <= {sda_q[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h68,
    parameter int         NUM_REGS = 20,
    parameter int         CLK_REGS = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  byte_t   rd_data,
    output byte_t   ptr,
    output reg_wr_t wr,
    output logic    freeze,
    output logic    sda_oe
);
    localparam byte_t LAST_ADDR = 8'(NUM_REGS - 1);
    localparam byte_t CLK_LIM   = 8'(CLK_REGS);

    eng_state_e state;
    logic [3:0] cnt;
    byte_t      sr;
    byte_t      tx;
    logic       rw;
    logic       first_wr;
    logic       busy;
    logic       mack;
    logic       ptr_load;

    assign ptr_load = (state == ST_WR_ACK) && first_wr && ev.scl_fall && !ev.start && !ev.stop;
    assign freeze   = busy && (ptr < CLK_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sr       <= '0;
            tx       <= '0;
            rw       <= 1'b0;
            first_wr <= 1'b0;
            busy     <= 1'b0;
            mack     <= 1'b0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
            wr       <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                busy   <= 1'b0;
            end else if (ev.start) begin
                state    <= ST_ADDR;
                cnt      <= '0;
                sda_oe   <= 1'b0;
                first_wr <= 1'b1;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (ev.scl_rise && cnt < 4'd8) begin
                            sr  <= {sr[6:0], ev.sda};
                            cnt <= cnt + 4'd1;
                        end else if (ev.scl_fall && cnt == 4'd8) begin
                            if (state == ST_ADDR) begin
                                if (sr[7:1] == DEV_ADDR) begin
                                    rw     <= sr[0];
                                    busy   <= 1'b1;
                                    sda_oe <= 1'b1;
                                    state  <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_HOLD;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                state  <= ST_WR_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[7];
                                state  <= ST_RD_BYTE;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WR_BYTE;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_WR_BYTE;
                            if (first_wr) begin
                                first_wr <= 1'b0;
                                ptr      <= (sr <= LAST_ADDR) ? sr : 8'd0;
                            end else begin
                                wr.en   <= 1'b1;
                                wr.addr <= ptr;
                                wr.data <= sr;
                                ptr     <= ptr_step(ptr, LAST_ADDR);
                            end
                        end
                    end
                    ST_RD_BYTE: begin
                        if (ev.scl_fall) begin
                            if (cnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RD_ACK;
                            end else begin
                                tx     <= {tx[6:0], 1'b0};
                                sda_oe <= ~tx[6];
                                cnt    <= cnt + 4'd1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.scl_rise) begin
                            mack <= ~ev.sda;
                            if (!ev.sda) begin
                                ptr <= ptr_step(ptr, LAST_ADDR);
                            end
                        end else if (ev.scl_fall) begin
                            if (mack) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[7];
                                cnt    <= '0;
                                state  <= ST_RD_BYTE;
                            end else begin
                                state <= ST_HOLD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        ptr <= LAST_ADDR); // R6

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (ptr != $past(ptr)) && !$past(ptr_load) |-> ptr == ptr_step($past(ptr), LAST_ADDR)); // R3

    AST_HOLD_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> !sda_oe); // R4

    AST_OE_ADDRESSED: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> busy); // R1

endmodule

// File: rtl/i2c_rf_regs.sv
module i2c_rf_regs
    import i2c_rf_pkg::*;
#(
    parameter int NUM_REGS = 20,
    parameter int CLK_REGS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CLK_REGS*8-1:0] time_i,
    input  logic                  freeze,
    input  reg_wr_t               wr,
    input  byte_t                 rd_addr,
    output byte_t                 rd_data
);
    localparam int    DATA_REGS = NUM_REGS - CLK_REGS;
    localparam int    AW        = $clog2(NUM_REGS);
    localparam byte_t LAST_ADDR = 8'(NUM_REGS - 1);

    logic [CLK_REGS-1:0][7:0]  clk_bank;
    logic [DATA_REGS-1:0][7:0] data_bank;
    logic [NUM_REGS-1:0][7:0]  all_regs;

    generate
        for (genvar k = 0; k < CLK_REGS; k++) begin : g_clk
            always_ff @(posedge clk) begin
                if (rst) begin
                    clk_bank[k] <= '0;
                end else if (wr.en && wr.addr == 8'(k)) begin
                    clk_bank[k] <= wr.data;
                end else if (!freeze) begin
                    clk_bank[k] <= time_i[8*k +: 8];
                end
            end
        end
        for (genvar k = 0; k < DATA_REGS; k++) begin : g_data
            always_ff @(posedge clk) begin
                if (rst) begin
                    data_bank[k] <= '0;
                end else if (wr.en && wr.addr == 8'(k + CLK_REGS)) begin
                    data_bank[k] <= wr.data;
                end
            end
        end
    endgenerate

    assign all_regs = {data_bank, clk_bank};

    always_comb begin
        rd_data = '0;
        if (rd_addr <= LAST_ADDR) begin
            rd_data = all_regs[rd_addr[AW-1:0]];
        end
    end

    AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (rst)
        (freeze && !wr.en) |=> $stable(clk_bank)); // R8

    AST_DATA_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> $stable(data_bank)); // R2

endmodule

// File: rtl/i2c_rf_top.sv
module i2c_rf_top
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         NUM_REGS    = 20,
    parameter int         CLK_REGS    = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic [CLK_REGS*8-1:0] time_i,
    output logic                  sda_oe
);
    bus_ev_t ev;
    byte_t   ptr;
    byte_t   rd_data;
    reg_wr_t wr;
    logic    freeze;

    i2c_rf_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_rf_engine #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS),
        .CLK_REGS (CLK_REGS)
    ) u_engine (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_data (rd_data),
        .ptr     (ptr),
        .wr      (wr),
        .freeze  (freeze),
        .sda_oe  (sda_oe)
    );

    i2c_rf_regs #(
        .NUM_REGS (NUM_REGS),
        .CLK_REGS (CLK_REGS)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .time_i  (time_i),
        .freeze  (freeze),
        .wr      (wr),
        .rd_addr (ptr),
        .rd_data (rd_data)
    );

endmodule

// File: tb/i2c_rf_top_test.sv
module i2c_rf_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int NREG       = 20;
    localparam logic [7:0] AW_B = 8'hD0;
    localparam logic [7:0] AR_B = 8'hD1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [63:0] tv = 64'h0;
    logic        sda_oe;
    logic        sda_line;

    int vectors = 0;
    int fails   = 0;
    logic done  = 1'b0;

    logic [7:0] mdata [NREG];
    logic [7:0] m_ptr;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_rf_top uut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .time_i (tv),
        .sda_oe (sda_oe)
    );

    function automatic logic [7:0] step(input logic [7:0] p);
        return (p >= 8'(NREG - 1)) ? 8'd0 : p + 8'd1;
    endfunction

    function automatic logic [7:0] load(input logic [7:0] v);
        return (v < 8'(NREG)) ? v : 8'd0;
    endfunction

    function automatic logic [7:0] exp_byte(input logic [7:0] a, input logic [63:0] t);
        return (a < 8'd8) ? t[8*a +: 8] : mdata[a];
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic bus_wait(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; bus_wait(Q);
        scl_m = 1'b1; bus_wait(Q);
        sda_m = 1'b0; bus_wait(Q);
        scl_m = 1'b0; bus_wait(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; bus_wait(Q);
        scl_m = 1'b1; bus_wait(Q);
        sda_m = 1'b1; bus_wait(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; bus_wait(Q);
            scl_m = 1'b1; bus_wait(2*Q);
            scl_m = 1'b0; bus_wait(Q);
        end
        sda_m = 1'b1; bus_wait(Q);
        scl_m = 1'b1; bus_wait(Q);
        ack = ~sda_line; bus_wait(Q);
        scl_m = 1'b0; bus_wait(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            bus_wait(Q);
            scl_m = 1'b1; bus_wait(Q);
            b[i] = sda_line; bus_wait(Q);
            scl_m = 1'b0; bus_wait(Q);
        end
        sda_m = ~give_ack; bus_wait(Q);
        scl_m = 1'b1; bus_wait(2*Q);
        scl_m = 1'b0; bus_wait(Q);
        sda_m = 1'b1;
    endtask

    task automatic addr_phase(input logic [7:0] a, input logic exp_ack, input string req);
        logic ack;
        send_byte(a, ack);
        check(req, {7'd0, ack}, {7'd0, exp_ack});
    endtask

    task automatic read_check(input int n, input string req);
        logic [7:0] got;
        for (int j = 0; j < n; j++) begin
            recv_byte(j < n - 1, got);
            check(req, got, exp_byte(m_ptr, tv));
            if (j < n - 1) m_ptr = step(m_ptr);
        end
    endtask

    task automatic write_xfer(input logic [7:0] p, input int n, input logic [31:0] pl);
        logic ack;
        i2c_start();
        addr_phase(AW_B, 1'b1, "R1");
        send_byte(p, ack);
        check("R2", {7'd0, ack}, 8'd1);
        m_ptr = load(p);
        for (int j = 0; j < n; j++) begin
            send_byte(pl[8*j +: 8], ack);
            check("R2", {7'd0, ack}, 8'd1);
            if (m_ptr >= 8'd8) mdata[m_ptr] = pl[8*j +: 8];
            m_ptr = step(m_ptr);
        end
        i2c_stop();
    endtask

    task automatic comb_read(input logic [7:0] p, input int n);
        logic ack;
        i2c_start();
        addr_phase(AW_B, 1'b1, "R1");
        send_byte(p, ack);
        check("R2", {7'd0, ack}, 8'd1);
        m_ptr = load(p);
        i2c_start();
        addr_phase(AR_B, 1'b1, "R3");
        read_check(n, "R3");
        i2c_stop();
    endtask

    task automatic cur_read(input int n, input string req);
        i2c_start();
        addr_phase(AR_B, 1'b1, "R5");
        read_check(n, req);
        i2c_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] got;
        logic [7:0] p;
        int         seed;
        int         kind;
        int         n;

        seed = 32'h5EED_1234;
        void'($urandom(seed));
        for (int i = 0; i < NREG; i++) mdata[i] = 8'h00;
        m_ptr = 8'h00;
        tv    = 64'h8877_6655_4433_2211;

        repeat (5) @(posedge clk);
        #1;
        rst = 1'b0;
        bus_wait(4);
        check("R10", {7'd0, sda_oe}, 8'd0);

        // R6: pointer starts at 00h; R7 mirror of time byte 0
        cur_read(1, "R6");

        // R10 data registers zero, then R6 wrap 13h -> 00h inside one burst
        comb_read(8'h08, 13);
        check("R6", m_ptr, 8'h00);

        // R1: foreign address ignored, no ack for its data either
        i2c_start();
        addr_phase(8'hA0, 1'b0, "R1");
        addr_phase(8'h05, 1'b0, "R1");
        check("R1", {7'd0, sda_oe}, 8'd0);
        i2c_stop();
        cur_read(1, "R1");

        // R2 write with wrap, then R5 current-address read
        write_xfer(8'h11, 3, 32'h00C3_B2A1);
        check("R6", m_ptr, 8'h00);
        write_xfer(8'h12, 0, 32'h0);
        cur_read(2, "R5");

        // R2 out-of-range pointer load lands on 00h
        write_xfer(8'h40, 0, 32'h0);
        cur_read(1, "R2");

        // R4 NACK releases SDA until STOP
        i2c_start();
        addr_phase(AR_B, 1'b1, "R4");
        recv_byte(1'b0, got);
        check("R4", got, exp_byte(m_ptr, tv));
        for (int k = 0; k < 3; k++) begin
            bus_wait(Q);
            check("R4", {7'd0, sda_oe}, 8'd0);
        end
        i2c_stop();

        // R8 snapshot across time change, R9 resume on STOP
        tv = 64'hA7A6_A5A4_A3A2_A1A0;
        i2c_start();
        addr_phase(AW_B, 1'b1, "R8");
        send_byte(8'h00, ack);
        i2c_start();
        addr_phase(AR_B, 1'b1, "R8");
        recv_byte(1'b1, got);
        check("R8", got, 8'hA0);
        tv = 64'hB7B6_B5B4_B3B2_B1B0;
        recv_byte(1'b1, got); check("R8", got, 8'hA1);
        recv_byte(1'b1, got); check("R8", got, 8'hA2);
        recv_byte(1'b0, got); check("R8", got, 8'hA3);
        i2c_stop();
        m_ptr = 8'h03;
        cur_read(1, "R9");

        // R9 resume when pointer steps into 08h-13h, refreeze after wrap
        tv = 64'hC7C6_C5C4_C3C2_C1C0;
        i2c_start();
        addr_phase(AW_B, 1'b1, "R9");
        send_byte(8'h06, ack);
        i2c_start();
        addr_phase(AR_B, 1'b1, "R9");
        recv_byte(1'b1, got); check("R8", got, 8'hC6);
        tv = 64'hD7D6_D5D4_D3D2_D1D0;
        recv_byte(1'b1, got); check("R8", got, 8'hC7);
        for (int a = 8; a < NREG; a++) begin
            if (a == 10) tv = 64'hE7E6_E5E4_E3E2_E1E0;
            recv_byte(1'b1, got);
            check("R9", got, mdata[a]);
        end
        recv_byte(1'b0, got);
        check("R9", got, 8'hE0);
        i2c_stop();
        m_ptr = 8'h00;

        // Random mix checked against the reference model (R2 R3 R5 R7)
        for (int t = 0; t < 25; t++) begin
            tv   = {$urandom, $urandom};
            kind = $urandom_range(2, 0);
            n    = $urandom_range(4, 1);
            if (kind == 0) begin
                p = 8'($urandom_range(NREG - 1, 8));
                write_xfer(p, n, $urandom);
            end else if (kind == 1) begin
                p = ($urandom_range(3, 0) == 0) ? 8'($urandom) : 8'($urandom_range(NREG - 1, 0));
                comb_read(p, n);
            end else begin
                cur_read(n, "R7");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule